// File: doc/BRIEF.md
# Descriptor-Chain DMA Walker

This block is the control half of one DMA channel. Software lays out a chain of descriptors in memory and hands the block the address of the first one. For each descriptor the block reads the five words it needs (source address, destination address, next pointer, and the two control words) over a simple request/acknowledge memory port. It then hands one block transfer to an external data mover and waits for that mover to report completion. After that it writes the control-high word back with a done flag set. Finally it either follows the next pointer or ends the chain.

A descriptor occupies seven 32-bit words in memory. The walker reads only the first five, and it writes back only the fifth. Chaining is allowed when either the source-side or the destination-side link bit is set. A next pointer whose address part is zero ends the chain. The two low bits of each pointer select the memory master used for the following accesses. The block pulses once after each descriptor and once more when the whole chain is finished. At that point its channel-enable output drops by itself.

The walker moves through seven named states:
- IDLE waits for `start`.
- FETCH reads the five words in turn.
- DECODE chooses between launching a transfer and skipping straight to the write-back.
- LAUNCH pulses the mover.
- MOVE waits for the mover's done signal.
- WBACK writes the done flag.
- ADVANCE emits the pulses and either returns to FETCH for the next descriptor or goes to IDLE.

Top module: `lldma_chain_walker`

## Requirements
- R1: While `rst_n` is low, and in the cycle after its release, `chan_en`, `mem_req`, `mv_start`, `blk_done` and `chain_done` are all 0.
- R2: A `start` pulse in idle causes five reads, in order, at byte addresses base+0, +4, +8, +12 and +16. Here base is `head_ptr` with bits 1:0 cleared. `mem_sel` equals `head_ptr[1:0]` for these reads. `mem_req` and `mem_addr` hold steady until `mem_ack`, and `mem_addr[1:0]` is always 0.
- R3: A transfer is started by a one-cycle `mv_start`. It carries the source word as `mv_src`, the destination word as `mv_dst` and the item count from control-high bits 11:0.
- R4: An item count above 2048 is presented to the mover as 2048.
- R5: A descriptor with an item count of 0 raises no `mv_start`. It is still written back and still counted by `blk_done`.
- R6: After the mover's `mv_done`, or straight after DECODE when the count is 0, the block makes exactly one write. It goes to base+16, with data equal to the fetched control-high word with bit 12 set, and it uses the same `mem_sel` as that descriptor's reads.
- R7: If control-low bit 28 (source link) or bit 27 (destination link) is set, and next-pointer bits 31:2 are non-zero, the next descriptor is fetched. Its base is the next pointer with bits 1:0 cleared, and `mem_sel` is next-pointer bits 1:0.
- R8: If both link bits are 0, or next-pointer bits 31:2 are 0, the chain ends after the current descriptor. This holds even when the next pointer's bits 1:0 are non-zero.
- R9: `blk_done` pulses once per descriptor, after its write-back is acknowledged. `chain_done` pulses only for the last descriptor, in the same cycle as its `blk_done`. `chan_en` is 0 in the following cycle.
- R10: `start` is ignored while `chan_en` is 1.
- R11: Control-low bits 10:9 give the source address mode and bits 8:7 give the destination address mode. The raw value 00 means increment, 01 means decrement, and 1x means no change. These appear on `mv_src_mode` and `mv_dst_mode` as 0, 1 and 2 respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin walking the chain at `head_ptr` |
| head_ptr | input | 32 | First descriptor address; bits 1:0 are the master select |
| chan_en | output | 1 | Channel busy; clears when the chain ends |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 for the write-back, 0 for descriptor reads |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_sel | output | 2 | Master select for the access |
| mem_wdata | output | 32 | Write-back data |
| mem_ack | input | 1 | Access accepted; read data valid in this cycle |
| mem_rdata | input | 32 | Read data |
| mv_start | output | 1 | One-cycle block transfer request |
| mv_src | output | 32 | Block source address |
| mv_dst | output | 32 | Block destination address |
| mv_items | output | 12 | Block length in items, at most 2048 |
| mv_src_mode | output | 2 | Source address mode: 0 increment, 1 decrement, 2 fixed |
| mv_dst_mode | output | 2 | Destination address mode, same coding |
| mv_done | input | 1 | Mover reports the block finished |
| blk_done | output | 1 | Pulse per completed descriptor |
| chain_done | output | 1 | Pulse when the last descriptor completes |

## Verification
The hardest situation to reach is the end of a chain where the next pointer's address part is zero but its select bits are not. Reaching it needs a chain whose last descriptor still carries link bits. The bench therefore sweeps chain lengths 1 to 4 against all four link-bit combinations. The last pointer of each chain carries only select bits, and every other pointer carries a different select value. A second hard case is a zero-length block in the middle of a chain. This is reached by rotating item counts (0, 1, 5, 2048, 2049, 4095) across descriptor positions, so zeros and the clamp values land at different depths. A start pulse is also injected while one chain is still running.

// File: rtl/lldma_pkg.sv
package lldma_pkg;
    localparam int WORD_BYTES    = 4;
    localparam int FETCH_WORDS   = 5;
    localparam int IDX_SRC       = 0;
    localparam int IDX_DST       = 1;
    localparam int IDX_NEXT      = 2;
    localparam int IDX_CLO       = 3;
    localparam int IDX_CHI       = 4;
    localparam int DONE_BIT      = 12;
    localparam int SRC_LINK_BIT  = 28;
    localparam int DST_LINK_BIT  = 27;
    localparam int SRC_MODE_LSB  = 9;
    localparam int DST_MODE_LSB  = 7;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_LAUNCH,
        ST_MOVE,
        ST_WBACK,
        ST_ADVANCE
    } walk_state_e;

    typedef enum logic [1:0] {
        AM_INC = 2'd0,
        AM_DEC = 2'd1,
        AM_FIX = 2'd2
    } addr_mode_e;

    function automatic addr_mode_e decode_mode(input logic [1:0] raw);
        if (raw[1])      return AM_FIX;
        else if (raw[0]) return AM_DEC;
        else             return AM_INC;
    endfunction
endpackage

// File: rtl/lldma_desc_store.sv
module lldma_desc_store #(
    parameter int DW = 32,
    parameter int NW = 5,
    localparam int IW = $clog2(NW)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ld,
    input  logic [IW-1:0]          ld_idx,
    input  logic [DW-1:0]          ld_data,
    output logic [NW-1:0][DW-1:0]  words_o
);
    for (genvar i = 0; i < NW; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                words_o[i] <= '0;
            else if (ld && (ld_idx == IW'(i)))
                words_o[i] <= ld_data;
        end
    end
endmodule

// File: rtl/lldma_block_decode.sv
module lldma_block_decode
    import lldma_pkg::*;
#(
    parameter int DW        = 32,
    parameter int NW        = 5,
    parameter int ITEM_W    = 12,
    parameter int MAX_ITEMS = 2048
) (
    input  logic [NW-1:0][DW-1:0] words_i,
    output logic [DW-1:0]         src_o,
    output logic [DW-1:0]         dst_o,
    output logic [ITEM_W-1:0]     items_o,
    output logic                  items_zero_o,
    output addr_mode_e            src_mode_o,
    output addr_mode_e            dst_mode_o,
    output logic                  chain_go_o,
    output logic [DW-1:0]         next_base_o,
    output logic [1:0]            next_sel_o,
    output logic [DW-1:0]         wb_word_o
);
    localparam logic [ITEM_W-1:0] ITEM_CAP = ITEM_W'(MAX_ITEMS);

    logic [DW-1:0]     ctl_lo;
    logic [DW-1:0]     ctl_hi;
    logic [DW-1:0]     nxt;
    logic [ITEM_W-1:0] items_raw;

    always_comb begin
        ctl_lo       = words_i[IDX_CLO];
        ctl_hi       = words_i[IDX_CHI];
        nxt          = words_i[IDX_NEXT];
        items_raw    = ctl_hi[ITEM_W-1:0];
        src_o        = words_i[IDX_SRC];
        dst_o        = words_i[IDX_DST];
        items_o      = (items_raw > ITEM_CAP) ? ITEM_CAP : items_raw;
        items_zero_o = (items_raw == '0);
        src_mode_o   = decode_mode(ctl_lo[SRC_MODE_LSB +: 2]);
        dst_mode_o   = decode_mode(ctl_lo[DST_MODE_LSB +: 2]);
        next_base_o  = {nxt[DW-1:2], 2'b00};
        next_sel_o   = nxt[1:0];
        chain_go_o   = (ctl_lo[SRC_LINK_BIT] || ctl_lo[DST_LINK_BIT])
                       && (nxt[DW-1:2] != '0);
        wb_word_o    = ctl_hi | (DW'(1) << DONE_BIT);
    end
endmodule

// File: rtl/lldma_chain_walker.sv
module lldma_chain_walker
    import lldma_pkg::*;
#(
    parameter int DW        = 32,
    parameter int ITEM_W    = 12,
    parameter int MAX_ITEMS = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DW-1:0]     head_ptr,
    output logic              chan_en,
    output logic              mem_req,
    output logic              mem_we,
    output logic [DW-1:0]     mem_addr,
    output logic [1:0]        mem_sel,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    output logic              mv_start,
    output logic [DW-1:0]     mv_src,
    output logic [DW-1:0]     mv_dst,
    output logic [ITEM_W-1:0] mv_items,
    output logic [1:0]        mv_src_mode,
    output logic [1:0]        mv_dst_mode,
    input  logic              mv_done,
    output logic              blk_done,
    output logic              chain_done
);
    localparam int NW = FETCH_WORDS;
    localparam int IW = $clog2(NW);
    localparam logic [IW-1:0] LAST_IDX = IW'(NW - 1);
    localparam logic [DW-1:0] WB_OFFSET = DW'(IDX_CHI * WORD_BYTES);

    walk_state_e state_q;
    logic [IW-1:0]        idx_q;
    logic [DW-1:0]        base_q;
    logic [1:0]           sel_q;
    logic [NW-1:0][DW-1:0] words;

    logic [DW-1:0]        d_src, d_dst, d_next_base, d_wb;
    logic [ITEM_W-1:0]    d_items;
    logic                 d_zero, d_go;
    addr_mode_e           d_smode, d_dmode;
    logic [1:0]           d_next_sel;
    logic                 fetch_ld;

    assign fetch_ld = (state_q == ST_FETCH) && mem_ack;

    lldma_desc_store #(.DW(DW), .NW(NW)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld      (fetch_ld),
        .ld_idx  (idx_q),
        .ld_data (mem_rdata),
        .words_o (words)
    );

    lldma_block_decode #(.DW(DW), .NW(NW), .ITEM_W(ITEM_W), .MAX_ITEMS(MAX_ITEMS)) dec_i (
        .words_i      (words),
        .src_o        (d_src),
        .dst_o        (d_dst),
        .items_o      (d_items),
        .items_zero_o (d_zero),
        .src_mode_o   (d_smode),
        .dst_mode_o   (d_dmode),
        .chain_go_o   (d_go),
        .next_base_o  (d_next_base),
        .next_sel_o   (d_next_sel),
        .wb_word_o    (d_wb)
    );

    // state register and walk bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            base_q  <= '0;
            sel_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    base_q  <= {head_ptr[DW-1:2], 2'b00};
                    sel_q   <= head_ptr[1:0];
                    idx_q   <= '0;
                    state_q <= ST_FETCH;
                end
                ST_FETCH: if (mem_ack) begin
                    if (idx_q == LAST_IDX) state_q <= ST_DECODE;
                    else                   idx_q   <= idx_q + 1'b1;
                end
                ST_DECODE:  state_q <= d_zero ? ST_WBACK : ST_LAUNCH;
                ST_LAUNCH:  state_q <= ST_MOVE;
                ST_MOVE:    if (mv_done) state_q <= ST_WBACK;
                ST_WBACK:   if (mem_ack) state_q <= ST_ADVANCE;
                ST_ADVANCE: begin
                    if (d_go) begin
                        base_q  <= d_next_base;
                        sel_q   <= d_next_sel;
                        idx_q   <= '0;
                        state_q <= ST_FETCH;
                    end else begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        chan_en     = (state_q != ST_IDLE);
        mem_req     = (state_q == ST_FETCH) || (state_q == ST_WBACK);
        mem_we      = (state_q == ST_WBACK);
        mem_sel     = sel_q;
        mem_addr    = (state_q == ST_WBACK) ? (base_q + WB_OFFSET)
                                            : (base_q + DW'({idx_q, 2'b00}));
        mem_wdata   = d_wb;
        mv_start    = (state_q == ST_LAUNCH);
        mv_src      = d_src;
        mv_dst      = d_dst;
        mv_items    = d_items;
        mv_src_mode = d_smode;
        mv_dst_mode = d_dmode;
        blk_done    = (state_q == ST_ADVANCE);
        chain_done  = (state_q == ST_ADVANCE) && !d_go;
    end

    AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R2
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R2
    AST_ITEMS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        mv_start |-> (mv_items <= ITEM_W'(MAX_ITEMS))); // R4
    AST_NO_EMPTY_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        mv_start |-> (mv_items != '0)); // R5
    AST_WB_DONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_wdata[DONE_BIT]); // R6
    AST_CHAIN_WITH_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done |-> blk_done); // R9
    AST_EN_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        chain_done |=> !chan_en); // R9
    AST_BUSY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en && !chain_done) |=> chan_en); // R10
endmodule

// File: tb/lldma_chain_walker_tb.sv
module lldma_chain_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] head_ptr = '0;
    logic        chan_en, mem_req, mem_we, mv_start, blk_done, chain_done;
    logic [31:0] mem_addr, mem_wdata, mv_src, mv_dst;
    logic [1:0]  mem_sel, mv_src_mode, mv_dst_mode;
    logic [11:0] mv_items;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mv_done = 1'b0;

    int n_checks = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    lldma_chain_walker dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .head_ptr(head_ptr),
        .chan_en(chan_en), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_sel(mem_sel), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mv_start(mv_start),
        .mv_src(mv_src), .mv_dst(mv_dst), .mv_items(mv_items),
        .mv_src_mode(mv_src_mode), .mv_dst_mode(mv_dst_mode),
        .mv_done(mv_done), .blk_done(blk_done), .chain_done(chain_done)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    logic [31:0] mem [0:255];
    logic [31:0] a_addr [0:63];
    logic [31:0] a_data [0:63];
    logic        a_we   [0:63];
    logic [1:0]  a_sel  [0:63];
    int          a_n = 0;
    logic [31:0] m_src [0:15];
    logic [31:0] m_dst [0:15];
    logic [11:0] m_items [0:15];
    logic [1:0]  m_sm [0:15];
    logic [1:0]  m_dm [0:15];
    int          m_n = 0;
    int          mv_cnt = 0;
    int          blk_cnt = 0;
    int          chain_cnt = 0;
    bit          prev_chain = 1'b0;

    // memory model: acknowledge every other cycle while requested
    always @(negedge clk) begin
        if (mem_ack) mem_ack = 1'b0;
        else if (mem_req) begin
            mem_ack = 1'b1;
            if (mem_we) mem[mem_addr[9:2]] = mem_wdata;
            else        mem_rdata = mem[mem_addr[9:2]];
            if (a_n < 64) begin
                a_addr[a_n] = mem_addr; a_data[a_n] = mem_wdata;
                a_we[a_n] = mem_we; a_sel[a_n] = mem_sel;
            end
            a_n++;
        end
    end

    // data mover model and pulse monitor
    always @(negedge clk) begin
        mv_done = 1'b0;
        if (mv_cnt > 0) begin
            mv_cnt--;
            if (mv_cnt == 0) mv_done = 1'b1;
        end
        if (mv_start) begin
            if (m_n < 16) begin
                m_src[m_n] = mv_src; m_dst[m_n] = mv_dst; m_items[m_n] = mv_items;
                m_sm[m_n] = mv_src_mode; m_dm[m_n] = mv_dst_mode;
            end
            m_n++;
            mv_cnt = 1 + int'(mv_items % 3);
        end
        if (prev_chain) chk(!chan_en, "R9 chan_en after chain_done", 32'(chan_en), 0);
        prev_chain = chain_done;
        if (blk_done) blk_cnt++;
        if (chain_done) begin
            chain_cnt++;
            chk(blk_done, "R9 chain_done with blk_done", 32'(blk_done), 1);
        end
    end

    function automatic logic [11:0] pick_items(input int i);
        case (i % 6)
            0: return 12'd0;
            1: return 12'd5;
            2: return 12'd2048;
            3: return 12'd4095;
            4: return 12'd1;
            default: return 12'd2049;
        endcase
    endfunction

    function automatic logic [1:0] mode_code(input logic [1:0] raw);
        return raw[1] ? 2'd2 : (raw[0] ? 2'd1 : 2'd0);
    endfunction

    function automatic logic [31:0] dbase(input int k);
        return 32'(64 + k * 64);
    endfunction

    task automatic run_chain(input int n, input int lm, input bit poke);
        logic [31:0] chi [0:3];
        logic [31:0] src_w [0:3];
        int blocks, exp_moves, mi, guard;
        for (int w = 0; w < 256; w++) mem[w] = 32'hDEAD_0000 | 32'(w);
        for (int k = 0; k < n; k++) begin
            logic [31:0] clo, nxt;
            logic [1:0]  sr, dr;
            int wi;
            sr = 2'((k + n) % 4);
            dr = 2'((k + lm + 1) % 4);
            clo = (32'(lm & 1) << 28) | (32'((lm >> 1) & 1) << 27)
                  | (32'(sr) << 9) | (32'(dr) << 7) | 32'h5;
            chi[k] = 32'hA5A5_0000 | 32'(pick_items(k + n + lm));
            src_w[k] = 32'h1000_0000 + 32'(k * 256 + n);
            nxt = (k < n - 1) ? (dbase(k + 1) | 32'((k + 1 + n) % 4)) : 32'((k + lm) % 4);
            wi = (64 + k * 64) / 4;
            mem[wi] = src_w[k];
            mem[wi + 1] = 32'h2000_0000 + 32'(k * 512 + lm);
            mem[wi + 2] = nxt;
            mem[wi + 3] = clo;
            mem[wi + 4] = chi[k];
        end
        a_n = 0; m_n = 0; blk_cnt = 0; chain_cnt = 0;
        @(negedge clk);
        head_ptr = dbase(0) | 32'(n % 4);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(chan_en, "R2 chan_en after start", 32'(chan_en), 1);
        if (poke) begin
            repeat (3) @(negedge clk);
            head_ptr = 32'h300;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        guard = 0;
        while (chan_en && guard < 5000) begin @(negedge clk); guard++; end
        repeat (3) @(negedge clk);
        blocks = (lm == 0) ? 1 : n;
        chk(a_n == 6 * blocks, "R7/R8 access count", 32'(a_n), 32'(6 * blocks));
        chk(blk_cnt == blocks, "R9 blk_done count", 32'(blk_cnt), 32'(blocks));
        chk(chain_cnt == 1, "R9 chain_done count", 32'(chain_cnt), 1);
        exp_moves = 0;
        for (int b = 0; b < blocks; b++) if (chi[b][11:0] != 0) exp_moves++;
        chk(m_n == exp_moves, "R5 move count", 32'(m_n), 32'(exp_moves));
        mi = 0;
        for (int b = 0; b < blocks && 6 * b + 5 < a_n; b++) begin
            logic [1:0] esel;
            logic [11:0] raw, eit;
            esel = 2'((b + n) % 4);
            for (int w = 0; w < 5; w++) begin
                chk(!a_we[6*b+w] && a_addr[6*b+w] == dbase(b) + 32'(4*w),
                    "R2/R7 fetch address", a_addr[6*b+w], dbase(b) + 32'(4*w));
                chk(a_sel[6*b+w] == esel, "R2/R7 fetch select", 32'(a_sel[6*b+w]), 32'(esel));
            end
            chk(a_we[6*b+5] && a_addr[6*b+5] == dbase(b) + 16, "R6 write-back address",
                a_addr[6*b+5], dbase(b) + 16);
            chk(a_data[6*b+5] == (chi[b] | 32'h1000), "R6 write-back data",
                a_data[6*b+5], chi[b] | 32'h1000);
            chk(a_sel[6*b+5] == esel, "R6 write-back select", 32'(a_sel[6*b+5]), 32'(esel));
            chk(mem[(64 + b*64)/4] == src_w[b], "R6 source word untouched",
                mem[(64 + b*64)/4], src_w[b]);
            raw = chi[b][11:0];
            if (raw != 0 && mi < m_n) begin
                eit = (raw > 12'd2048) ? 12'd2048 : raw;
                chk(m_src[mi] == src_w[b], "R3 mover source", m_src[mi], src_w[b]);
                chk(m_dst[mi] == 32'h2000_0000 + 32'(b * 512 + lm), "R3 mover destination",
                    m_dst[mi], 32'h2000_0000 + 32'(b * 512 + lm));
                chk(m_items[mi] == eit, "R4 mover items", 32'(m_items[mi]), 32'(eit));
                chk(m_sm[mi] == mode_code(2'((b + n) % 4)), "R11 source mode",
                    32'(m_sm[mi]), 32'(mode_code(2'((b + n) % 4))));
                chk(m_dm[mi] == mode_code(2'((b + lm + 1) % 4)), "R11 destination mode",
                    32'(m_dm[mi]), 32'(mode_code(2'((b + lm + 1) % 4))));
                mi++;
            end
        end
        if (poke) chk(a_addr[0] == dbase(0), "R10 start while busy ignored", a_addr[0], dbase(0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!chan_en && !mem_req && !mv_start && !blk_done && !chain_done,
            "R1 outputs in reset", {27'd0, chan_en, mem_req, mv_start, blk_done, chain_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!chan_en && !mem_req && !mv_start, "R1 idle after reset",
            {29'd0, chan_en, mem_req, mv_start}, 0);
        for (int n = 1; n <= 4; n++)
            for (int lm = 0; lm < 4; lm++)
                run_chain(n, lm, (n == 3 && lm == 3));
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_err++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule